// File: doc/BRIEF.md
# Oversampled Serial Receive Framer

This block turns an asynchronous serial line into received words. A separate rate generator supplies a clock-enable pulse at sixteen times the bit rate. The framer synchronises the line and counts those pulses from the detected start bit. It takes a three-sample majority near the middle of every bit and assembles the data least-significant bit first. At the end of the frame it presents the word with a one-clock strobe and a framing-error flag.

Two mode inputs select the frame shape. One chooses between eight and nine data bits, the other between one and two stop bits. Both are captured when a start bit is detected.

The last stop bit is decided at its tenth sub-bit sample, not at its end. The receiver then re-arms at once, so the next start bit is caught even when the sender's frame is a few percent shorter than nominal. An idle indication reports when the line has stayed high for a programmable number of bit times while no frame is in progress.

Top module: `serial_rx_frame`

## Requirements
- R1: A bit period is 16 `rt_tick` pulses. While hunting, once the line has been sampled high on a tick, the first tick that samples it low is sub-bit 1 of a start bit.
- R2: If the majority of the start bit's samples at sub-bits 8, 9 and 10 is high, the frame is dropped without a strobe and hunting resumes.
- R3: Each data and stop bit takes the majority of its samples at sub-bits 8, 9 and 10. A single disagreeing sample among the three does not change the bit.
- R4: Data arrives least-significant bit first. In nine-bit mode (`cfg_nine`=1) `rx_data` carries all nine bits. In eight-bit mode bit 8 of `rx_data` is 0.
- R5: With `cfg_two_stop`=1 two stop bits are checked, otherwise one. `rx_frame_err` is 1 when any checked stop bit votes low, and the data word is still delivered.
- R6: `rx_valid` is high for exactly one clock. It rises after the tick that is sub-bit 10 of the final stop bit, which is tick 16*(N-1)+9 counted from the start tick as 0, where N is the total number of bits in the frame. `rx_data` and `rx_frame_err` hold their values until the next strobe.
- R7: If the final stop bit votes high, a low sample on the very next tick starts a new frame. Back-to-back frames with no gap are received.
- R8: A frame is received without error when the sender's bits are up to 3.4% short for an 11-bit frame, and up to 3.1% short for a 12-bit frame.
- R9: `rx_idle` rises after IDLE_BITS*16 consecutive high ticks while hunting (IDLE_BITS defaults to 10). It falls when a start bit is detected.
- R10: After reset, `rx_valid`, `rx_frame_err`, `rx_data` and `rx_idle` are all 0.
- R11: The mode inputs are captured at start detection. Changing them during a frame does not alter that frame.
- R12: Nothing advances on a clock without `rt_tick`. A low line pulse between ticks that is gone by the next tick starts no frame and leaves `rx_idle` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rt_tick | input | 1 | Sampling enable, sixteen per bit period |
| rxd | input | 1 | Asynchronous serial line, idle high |
| cfg_nine | input | 1 | 1 selects nine data bits, 0 selects eight |
| cfg_two_stop | input | 1 | 1 selects two stop bits, 0 selects one |
| rx_data | output | DATA_W | Last received word, right-aligned |
| rx_valid | output | 1 | One-clock strobe when a word is delivered |
| rx_frame_err | output | 1 | Stop-bit error of the last delivered word |
| rx_idle | output | 1 | Line has been idle for IDLE_BITS bit times |

## Verification
The bench builds the block with its defaults: 16 sub-bits, a nine-bit data word, two synchroniser stages and a ten-bit idle threshold. It pulses `rt_tick` every third clock, so the synchroniser settles between ticks and each line change lands on a known sub-bit. This makes the strobe tick, the vote sample points and the fast-sender boundaries exact tick counts that can be computed from the requirements. The bench sweeps every eight-bit value back to back, and also covers a spread of nine-bit words in all four frame shapes, senders 3.4% and 3.1% fast, and single-sample glitches at each vote position.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic {
    RX_HUNT  = 1'b0,
    RX_FRAME = 1'b1
  } rx_state_e;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= RESET_VAL;
        else     chain_q <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RESET_VAL}};
        else     chain_q <= {chain_q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/rx_rt_sampler.sv
module rx_rt_sampler
  import serial_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic run,
  input  logic restart,
  input  logic din,
  output logic bit_end,
  output logic bit_vote,
  output logic bit_adv
);
  localparam int CW    = $clog2(OSR + 1);
  localparam int SMP_A = OSR / 2;
  localparam int SMP_B = SMP_A + 1;
  localparam int SMP_C = SMP_A + 2;

  logic [CW-1:0] rt_q;
  logic [CW-1:0] rt_now;
  logic          s_a_q, s_b_q;
  logic          active;

  assign rt_now = (rt_q == CW'(OSR)) ? CW'(1) : rt_q + CW'(1);
  assign active = tick && run && !restart;

  always_ff @(posedge clk) begin
    if (rst) begin
      rt_q  <= '0;
      s_a_q <= 1'b1;
      s_b_q <= 1'b1;
    end else if (tick) begin
      if (restart) begin
        rt_q <= CW'(1);
      end else if (run) begin
        rt_q <= rt_now;
        if (rt_now == CW'(SMP_A)) s_a_q <= din;
        if (rt_now == CW'(SMP_B)) s_b_q <= din;
      end
    end
  end

  assign bit_end  = active && (rt_now == CW'(SMP_C));
  assign bit_adv  = active && (rt_now == CW'(1));
  assign bit_vote = vote3(s_a_q, s_b_q, din);
endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer #(
  parameter int LIMIT = 160
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic hunting,
  input  logic line,
  input  logic clear,
  output logic idle
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
      idle  <= 1'b0;
    end else if (tick && hunting) begin
      if (line) begin
        if (cnt_q != CW'(LIMIT)) cnt_q <= cnt_q + CW'(1);
        idle <= (cnt_q >= CW'(LIMIT - 1));
      end else begin
        cnt_q <= '0;
        idle  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
  import serial_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int DATA_W      = 9,
  parameter int IDLE_BITS   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rt_tick,
  input  logic              rxd,
  input  logic              cfg_nine,
  input  logic              cfg_two_stop,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_frame_err,
  output logic              rx_idle
);
  localparam int IW         = $clog2(DATA_W + 4);
  localparam int IDLE_LIMIT = IDLE_BITS * OSR;

  rx_state_e         state_q;
  logic              line;
  logic              armed_q;
  logic [IW-1:0]     bit_idx_q;
  logic              nine_q, two_q;
  logic              ferr_acc_q;
  logic [DATA_W-1:0] shift_q;
  logic [IW-1:0]     n_data, last_idx;
  logic              start_det;
  logic              bit_end, bit_vote, bit_adv;

  rx_line_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (rxd),
    .dout(line)
  );

  assign start_det = rt_tick && (state_q == RX_HUNT) && armed_q && !line;

  rx_rt_sampler #(.OSR(OSR)) u_sampler (
    .clk     (clk),
    .rst     (rst),
    .tick    (rt_tick),
    .run     (state_q == RX_FRAME),
    .restart (start_det),
    .din     (line),
    .bit_end (bit_end),
    .bit_vote(bit_vote),
    .bit_adv (bit_adv)
  );

  rx_idle_timer #(.LIMIT(IDLE_LIMIT)) u_idle (
    .clk    (clk),
    .rst    (rst),
    .tick   (rt_tick),
    .hunting(state_q == RX_HUNT),
    .line   (line),
    .clear  (start_det),
    .idle   (rx_idle)
  );

  assign n_data   = nine_q ? IW'(DATA_W) : IW'(DATA_W - 1);
  assign last_idx = n_data + (two_q ? IW'(2) : IW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= RX_HUNT;
      armed_q      <= 1'b0;
      bit_idx_q    <= '0;
      nine_q       <= 1'b0;
      two_q        <= 1'b0;
      ferr_acc_q   <= 1'b0;
      shift_q      <= '0;
      rx_data      <= '0;
      rx_valid     <= 1'b0;
      rx_frame_err <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (rt_tick) begin
        case (state_q)
          RX_HUNT: begin
            if (start_det) begin
              state_q    <= RX_FRAME;
              bit_idx_q  <= '0;
              nine_q     <= cfg_nine;
              two_q      <= cfg_two_stop;
              ferr_acc_q <= 1'b0;
            end else begin
              armed_q <= line;
            end
          end
          RX_FRAME: begin
            if (bit_adv) bit_idx_q <= bit_idx_q + IW'(1);
            if (bit_end) begin
              if (bit_idx_q == '0) begin
                if (bit_vote) begin
                  state_q <= RX_HUNT;
                  armed_q <= 1'b1;
                end
              end else if (bit_idx_q <= n_data) begin
                shift_q <= {bit_vote, shift_q[DATA_W-1:1]};
              end else begin
                if (!bit_vote) ferr_acc_q <= 1'b1;
                if (bit_idx_q == last_idx) begin
                  state_q      <= RX_HUNT;
                  armed_q      <= bit_vote;
                  rx_valid     <= 1'b1;
                  rx_frame_err <= ferr_acc_q | !bit_vote;
                  rx_data      <= nine_q ? shift_q : {1'b0, shift_q[DATA_W-1:1]};
                end
              end
            end
          end
          default: state_q <= RX_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/rx_frame_chk.sv
module rx_frame_chk #(
  parameter int DATA_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              rt_tick,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_valid,
  input logic              rx_frame_err,
  input logic              rx_idle
);
  // R6
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R12
  strobe_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $past(rt_tick));

  // R6
  word_held_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |-> ($stable(rx_data) && $stable(rx_frame_err)));

  // R9
  idle_vs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> !rx_idle);

  // R12
  idle_rise_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_idle) |-> $past(rt_tick));

  // R10
  reset_values_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rx_valid && !rx_idle && !rx_frame_err && rx_data == '0));
endmodule

bind serial_rx_frame rx_frame_chk #(.DATA_W(DATA_W)) u_frame_chk (
  .clk         (clk),
  .rst         (rst),
  .rt_tick     (rt_tick),
  .rx_data     (rx_data),
  .rx_valid    (rx_valid),
  .rx_frame_err(rx_frame_err),
  .rx_idle     (rx_idle)
);

// File: tb/serial_rx_frame_test.sv
module serial_rx_frame_test;
  localparam int OSR    = 16;
  localparam int DATA_W = 9;
  localparam int WD_MAX = 199000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              rt_tick = 1'b0;
  logic              rxd = 1'b1;
  logic              cfg_nine = 1'b0;
  logic              cfg_two_stop = 1'b0;
  logic [DATA_W-1:0] rx_data;
  logic              rx_valid, rx_frame_err, rx_idle;

  int  n_chk = 0;
  int  n_bad = 0;
  int  cyc = 0;
  bit  done = 0;
  bit  idle_probe = 0;

  serial_rx_frame uut (
    .clk(clk), .rst(rst), .rt_tick(rt_tick), .rxd(rxd),
    .cfg_nine(cfg_nine), .cfg_two_stop(cfg_two_stop),
    .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_frame_err(rx_frame_err), .rx_idle(rx_idle)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_MAX && !done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one sub-bit: line set, two clocks to settle, then one clock with tick
  task automatic one_tick(input logic v);
    rxd = v;
    @(negedge clk);
    @(negedge clk);
    rt_tick = 1'b1;
    @(negedge clk);
    rt_tick = 1'b0;
  endtask

  function automatic int bnd(input int k, input int num, input int den);
    return (k * OSR * num) / den;
  endfunction

  task automatic send_frame(input logic [8:0] d, input bit nine, input bit two,
                            input int num, input int den,
                            input int gl_bit, input int gl_off,
                            input bit [1:0] stop_bad, input bit flip_cfg,
                            input int gap, input string req);
    int nd, ns, nb, total, exp_t, got, gt, k;
    logic v;
    logic [8:0] gd, ed;
    logic gf;
    nd = nine ? 9 : 8;
    ns = two ? 2 : 1;
    nb = 1 + nd + ns;
    total = bnd(nb, num, den);
    exp_t = OSR * (nb - 1) + 9;
    got = 0; gt = -1; gd = '0; gf = 1'b0;
    cfg_nine = nine;
    cfg_two_stop = two;
    for (int t = 0; t < total; t++) begin
      k = 0;
      while (bnd(k + 1, num, den) <= t) k++;
      if (k == 0)       v = 1'b0;
      else if (k <= nd) v = d[k-1];
      else              v = !stop_bad[k-nd-1];
      if (k == gl_bit && t == OSR * k + 7 + gl_off) v = !v;
      if (flip_cfg && t == 20) begin
        cfg_nine = !nine;
        cfg_two_stop = !two;
      end
      one_tick(v);
      if (idle_probe && t == 0) chk(rx_idle == 1'b0, "R9", "idle after start", rx_idle, 0);
      if (rx_valid) begin
        got++;
        gt = t;
        gd = rx_data;
        gf = rx_frame_err;
      end
    end
    for (int g = 0; g < gap; g++) begin
      one_tick(1'b1);
      if (rx_valid) got++;
    end
    cfg_nine = nine;
    cfg_two_stop = two;
    ed = nine ? d : {1'b0, d[7:0]};
    chk(got == 1, "R6", "strobe count", got, 1);
    chk(gt == exp_t, "R6", "strobe tick", gt, exp_t);
    chk(gd == ed, req, "data word", gd, ed);
    chk(gf == (|stop_bad), "R5", "frame error", gf, |stop_bad);
  endtask

  task automatic no_strobe(input int n, input string req, input string what);
    int cnt;
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      one_tick(1'b1);
      if (rx_valid) cnt++;
    end
    chk(cnt == 0, req, what, cnt, 0);
  endtask

  initial begin
    int lows;
    logic idle_before;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset values
    chk(rx_valid == 0, "R10", "valid after reset", rx_valid, 0);
    chk(rx_frame_err == 0, "R10", "ferr after reset", rx_frame_err, 0);
    chk(rx_data == 0, "R10", "data after reset", rx_data, 0);
    chk(rx_idle == 0, "R10", "idle after reset", rx_idle, 0);

    // R9: idle threshold of 160 high ticks
    for (int i = 0; i < 159; i++) one_tick(1'b1);
    chk(rx_idle == 0, "R9", "idle at 159 ticks", rx_idle, 0);
    one_tick(1'b1);
    chk(rx_idle == 1, "R9", "idle at 160 ticks", rx_idle, 1);

    // R1: first frame from idle line, idle drops at start
    idle_probe = 1;
    send_frame(9'h0A5, 1'b0, 1'b0, 1, 1, -1, 0, 2'b00, 1'b0, 4, "R1");
    idle_probe = 0;

    // R4: nine-bit words in every frame shape
    for (int i = 0; i < 24; i++) begin
      send_frame(9'((i * 173 + 5) % 512), 1'b1, i[0], 1, 1, -1, 0, 2'b00, 1'b0, 0, "R4");
    end
    send_frame(9'h1FF, 1'b1, 1'b1, 1, 1, -1, 0, 2'b00, 1'b0, 0, "R4");
    send_frame(9'h100, 1'b1, 1'b0, 1, 1, -1, 0, 2'b00, 1'b0, 0, "R4");
    send_frame(9'h1FF, 1'b0, 1'b1, 1, 1, -1, 0, 2'b00, 1'b0, 0, "R4");

    // R3: one disagreeing sample at each vote position
    for (int p = 0; p < 3; p++) begin
      send_frame(9'h0C3, 1'b0, 1'b0, 1, 1, 3, p, 2'b00, 1'b0, 0, "R3");
      send_frame(9'h13C, 1'b1, 1'b1, 1, 1, 9, p, 2'b00, 1'b0, 0, "R3");
    end

    // R5: stop-bit errors, data still delivered
    send_frame(9'h05A, 1'b0, 1'b0, 1, 1, -1, 0, 2'b01, 1'b0, 4, "R5");
    send_frame(9'h16B, 1'b1, 1'b1, 1, 1, -1, 0, 2'b01, 1'b0, 0, "R5");
    send_frame(9'h0F0, 1'b1, 1'b1, 1, 1, -1, 0, 2'b10, 1'b0, 4, "R5");

    // R11: mode inputs flipped mid-frame
    send_frame(9'h1A7, 1'b1, 1'b1, 1, 1, -1, 0, 2'b00, 1'b1, 0, "R11");
    send_frame(9'h03C, 1'b0, 1'b0, 1, 1, -1, 0, 2'b00, 1'b1, 2, "R11");

    // R8: fast sender, back to back: 11-bit at 3.4%, 12-bit at 3.125%
    for (int i = 0; i < 4; i++)
      send_frame(9'(9'h155 ^ (i * 37)), 1'b1, 1'b0, 483, 500, -1, 0, 2'b00, 1'b0, 0, "R8");
    for (int i = 0; i < 4; i++)
      send_frame(9'(9'h0AA ^ (i * 91)), 1'b1, 1'b1, 31, 32, -1, 0, 2'b00, 1'b0, 0, "R8");
    for (int i = 0; i < 2; i++)
      send_frame(9'(8'h81 + i), 1'b0, 1'b1, 31, 32, -1, 0, 2'b00, 1'b0, 0, "R8");
    no_strobe(4, "R8", "no extra strobe after fast run");

    // R2: short start pulses are discarded
    for (int i = 0; i < 3; i++) one_tick(1'b0);
    no_strobe(40, "R2", "3-tick start pulse");
    for (int i = 0; i < 8; i++) one_tick(1'b0);
    no_strobe(40, "R2", "8-tick start pulse");
    send_frame(9'h066, 1'b0, 1'b0, 1, 1, -1, 0, 2'b00, 1'b0, 0, "R2");

    // R12: a low pulse between ticks is never seen
    for (int i = 0; i < 170; i++) one_tick(1'b1);
    idle_before = rx_idle;
    chk(idle_before == 1, "R9", "idle before gap", idle_before, 1);
    rxd = 1'b0;
    repeat (6) @(negedge clk);
    lows = (rx_idle == idle_before) ? 0 : 1;
    rxd = 1'b1;
    repeat (4) @(negedge clk);
    chk(lows == 0, "R12", "idle during tickless pulse", lows, 0);
    chk(rx_idle == idle_before, "R12", "idle after tickless pulse", rx_idle, idle_before);
    no_strobe(30, "R12", "tickless pulse");

    // R7: every eight-bit value, back to back with no gap
    for (int v = 0; v < 256; v++)
      send_frame(9'(v), 1'b0, 1'b0, 1, 1, -1, 0, 2'b00, 1'b0, 0, "R7");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule